// File: doc/BRIEF.md
# Oscillator Loss Monitor with Shared Open-Drain Pin

This block watches the slow 32 kHz timekeeping oscillator from a faster reference clock. It counts reference cycles between the oscillator's rising edges. When no rising edge arrives for a window as long as four nominal oscillator periods, it raises a sticky fail flag. The flag comes up set out of reset. Only a software clear can drop it, and a clear loses to a gap that is still in progress.

The same block owns one open-drain pin that three functions share. The pin can be a fail interrupt (active low), a 512 Hz test square wave divided down from the oscillator, or a plain output bit written by software. On main power the pin source is chosen by a fixed priority. On backup power only the software bit reaches the pin. The pin is a registered drive-low request (1 = pull low, 0 = release). The fail flag is also brought out so that it can be read back.

Top module: `osc_loss_pin`

## Requirements
- R1: After a synchronous active-low reset the fail flag reads 1. The pin follows the selection rules with that flag value.
- R2: With `NOM_PERIOD`=8 and `MISS_RUN`=4, the flag is set when the spacing between oscillator rising edges reaches 5 nominal periods (four consecutive missed pulses) or more.
- R3: A steady oscillator does not set the flag. Neither does an edge spacing of up to 4 nominal periods (three missed pulses).
- R4: A one-cycle pulse on `flag_clr` clears the flag while the oscillator runs. The flag then stays 0 for as long as pulses keep arriving.
- R5: While the oscillator is still stopped past the threshold, setting wins over `flag_clr`, and the flag stays 1.
- R6: Detection and the flag work the same whether `irq_en` is 0 or 1.
- R7: On main power with `irq_en`=1, `pin_pull_low` is 1 exactly when the flag is 1. This holds whatever `ftest_en` and `out_bit` are.
- R8: On main power with `irq_en`=0 and `ftest_en`=1, the pin toggles once every 32 oscillator rising edges (a 512 Hz wave from 32768 Hz). That is 8 toggles in any window of 256 oscillator periods.
- R9: On main power with `irq_en`=0 and `ftest_en`=0, `pin_pull_low` equals the inverse of `out_bit`.
- R10: With `on_backup`=1, `pin_pull_low` equals the inverse of `out_bit`, regardless of `irq_en`, `ftest_en` and the flag. No test toggles appear.
- R11: `pin_pull_low` is registered. A control change made between clock edges shows on the pin only after the next rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_in | input | 1 | Oscillator level, asynchronous to `clk` |
| on_backup | input | 1 | 1 when running from the backup supply |
| irq_en | input | 1 | Fail interrupt enable |
| ftest_en | input | 1 | Frequency-test output select |
| out_bit | input | 1 | Software discrete output value |
| flag_clr | input | 1 | Register write that clears the fail flag |
| fail_flag | output | 1 | Sticky oscillator fail flag |
| pin_pull_low | output | 1 | Open-drain drive request, 1 = pull pin low |

## Verification
The hardest situations to reach are the exact edge-spacing boundary and a clear that races a gap still in progress. The bench generates the oscillator itself and can suppress a chosen number of whole pulses. It therefore produces spacings of exactly 4 and 5 nominal periods, on either side of the threshold. To create the race, it stops the oscillator altogether and pulses the clear long after the flag has risen. The test wave is judged by counting pin toggles over a fixed number of oscillator periods. That count does not depend on the phase of the divider.

// File: rtl/osc_loss_pkg.sv
// Package: shared types for the oscillator loss monitor.
// Assumes nothing beyond IEEE 1800-2017 enums.
package osc_loss_pkg;

    // Which function currently owns the shared pin
    typedef enum logic [1:0] {
        PIN_SRC_IRQ  = 2'd0,
        PIN_SRC_TONE = 2'd1,
        PIN_SRC_SOFT = 2'd2
    } pin_src_e;

endpackage

// File: rtl/osc_edge_sync.sv
// osc_edge_sync: brings the asynchronous oscillator level into the clk
// domain through a flop chain and emits a one-cycle pulse per rising edge.
// Assumes the oscillator is much slower than clk (several clk cycles per level).
module osc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic osc_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchronizer chain; stage 0 samples the raw level
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= osc_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign osc_rise = sync_q[SYNC_STAGES-1] & ~last_q;

    // A rise pulse never lasts two cycles
    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        osc_rise |=> !osc_rise); // R2

endmodule

// File: rtl/osc_gap_detect.sv
// osc_gap_detect: counts clk cycles since the last oscillator rise and
// sets a sticky fail flag once the count reaches MISS_RUN nominal periods.
// Assumes osc_rise is a clean single-cycle pulse. Setting beats clearing.
module osc_gap_detect #(
    parameter int NOM_PERIOD = 8,
    parameter int MISS_RUN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_rise,
    input  logic flag_clr,
    output logic fail_flag
);

    localparam int THRESH = NOM_PERIOD * MISS_RUN;
    localparam int CNT_W  = $clog2(THRESH + 1);
    localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESH);

    logic [CNT_W-1:0] gap_cnt;
    logic             gap_hit;
    logic             flag_q;

    // Saturating count of cycles since the most recent rise
    always_ff @(posedge clk) begin
        if (!rst_n)                  gap_cnt <= '0;
        else if (osc_rise)           gap_cnt <= '0;
        else if (gap_cnt != THRESH_V) gap_cnt <= gap_cnt + 1'b1;
    end

    assign gap_hit = (gap_cnt == THRESH_V);

    // Sticky flag: set on gap (wins), cleared by software write
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b1;
        else if (gap_hit)  flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign fail_flag = flag_q;

    AST_GAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        osc_rise |=> (gap_cnt == '0)); // R3
    AST_GAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        gap_hit |=> fail_flag); // R2
    AST_CLEAR_WINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !gap_hit) |=> !fail_flag); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !flag_clr) |=> fail_flag); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= THRESH_V); // R2

endmodule

// File: rtl/osc_tone_div.sv
// osc_tone_div: divides oscillator rises into a square wave that toggles
// every DIV_RATIO/2 rises (64 gives 512 Hz from 32768 Hz).
// Assumes DIV_RATIO is even and at least 2.
module osc_tone_div #(
    parameter int DIV_RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_rise,
    output logic tone
);

    localparam int HALF   = DIV_RATIO / 2;
    localparam int HCNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [HCNT_W-1:0] LAST_V = HCNT_W'(HALF - 1);

    logic [HCNT_W-1:0] half_cnt;
    logic              tone_q;

    // Count rises within a half period and flip the wave at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_cnt <= '0;
            tone_q   <= 1'b0;
        end else if (osc_rise) begin
            if (half_cnt == LAST_V) begin
                half_cnt <= '0;
                tone_q   <= ~tone_q;
            end else begin
                half_cnt <= half_cnt + 1'b1;
            end
        end
    end

    assign tone = tone_q;

    AST_TONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_rise |=> $stable(tone)); // R8
    AST_TONE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_rise && half_cnt == LAST_V) |=> (tone != $past(tone))); // R8

endmodule

// File: rtl/osc_pin_mux.sv
// osc_pin_mux: picks the owner of the shared open-drain pin and registers
// the drive-low request. Main power: interrupt, then test wave, then
// software bit. Backup: software bit only. Interrupt is active low.
module osc_pin_mux
    import osc_loss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_backup,
    input  logic irq_en,
    input  logic ftest_en,
    input  logic out_bit,
    input  logic fail_flag,
    input  logic tone,
    output logic pin_pull_low
);

    pin_src_e src;
    logic     pull_d;
    logic     pull_q;

    // Owner selection by power state and control priority
    always_comb begin
        if (on_backup)     src = PIN_SRC_SOFT;
        else if (irq_en)   src = PIN_SRC_IRQ;
        else if (ftest_en) src = PIN_SRC_TONE;
        else               src = PIN_SRC_SOFT;
    end

    // Drive-low request of the selected owner
    always_comb begin
        unique case (src)
            PIN_SRC_IRQ:  pull_d = fail_flag;
            PIN_SRC_TONE: pull_d = ~tone;
            default:      pull_d = ~out_bit;
        endcase
    end

    // Register the request so the pad sees a glitch-free level
    always_ff @(posedge clk) begin
        if (!rst_n) pull_q <= 1'b0;
        else        pull_q <= pull_d;
    end

    assign pin_pull_low = pull_q;

    AST_BACKUP_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        on_backup |=> (pin_pull_low == !$past(out_bit))); // R10
    AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_backup && irq_en) |=> (pin_pull_low == $past(fail_flag))); // R7
    AST_SOFT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (!on_backup && !irq_en && !ftest_en) |=> (pin_pull_low == !$past(out_bit))); // R9

endmodule

// File: rtl/osc_loss_pin.sv
// osc_loss_pin: top of the oscillator loss monitor. Synchronizes the
// oscillator, detects runs of missing pulses, derives the test wave and
// drives the shared open-drain pin. All logic runs on clk; osc_in is async.
module osc_loss_pin #(
    parameter int NOM_PERIOD  = 8,
    parameter int MISS_RUN    = 4,
    parameter int TONE_DIV    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic on_backup,
    input  logic irq_en,
    input  logic ftest_en,
    input  logic out_bit,
    input  logic flag_clr,
    output logic fail_flag,
    output logic pin_pull_low
);

    logic osc_rise;
    logic tone;

    osc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_in   (osc_in),
        .osc_rise (osc_rise)
    );

    osc_gap_detect #(.NOM_PERIOD(NOM_PERIOD), .MISS_RUN(MISS_RUN)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .osc_rise  (osc_rise),
        .flag_clr  (flag_clr),
        .fail_flag (fail_flag)
    );

    osc_tone_div #(.DIV_RATIO(TONE_DIV)) u_tone (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_rise (osc_rise),
        .tone     (tone)
    );

    osc_pin_mux u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .on_backup    (on_backup),
        .irq_en       (irq_en),
        .ftest_en     (ftest_en),
        .out_bit      (out_bit),
        .fail_flag    (fail_flag),
        .tone         (tone),
        .pin_pull_low (pin_pull_low)
    );

    AST_RESET_FLAG: assert property (@(posedge clk)
        !rst_n |=> fail_flag); // R1

endmodule

// File: tb/sim_osc_loss_pin.sv
// Scoreboard bench: driver tasks queue expected pin/flag states, the monitor
// pops and compares them at the falling edge of clk.
module sim_osc_loss_pin;

    localparam int NOM = 8;

    typedef struct {
        string req;
        bit    pin;
        bit    flag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_in = 1'b0;
    logic on_backup = 1'b0;
    logic irq_en = 1'b0;
    logic ftest_en = 1'b0;
    logic out_bit = 1'b1;
    logic flag_clr = 1'b0;
    logic fail_flag;
    logic pin_pull_low;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  osc_run = 1'b1;
    int  skip_req = 0;
    bit  done = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    osc_loss_pin u0 (
        .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .on_backup(on_backup),
        .irq_en(irq_en), .ftest_en(ftest_en), .out_bit(out_bit),
        .flag_clr(flag_clr), .fail_flag(fail_flag), .pin_pull_low(pin_pull_low)
    );

    // Oscillator model: one period is NOM clk cycles; pulses can be skipped
    initial begin
        forever begin
            @(negedge clk);
            if (skip_req > 0) begin
                skip_req = skip_req - 1;
                repeat (NOM - 1) @(negedge clk);
            end else if (osc_run) begin
                osc_in = 1'b1;
                repeat (NOM / 2) @(negedge clk);
                osc_in = 1'b0;
                repeat (NOM / 2 - 1) @(negedge clk);
            end
        end
    end

    // Monitor: compare queued expectations just after the falling edge
    always @(negedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (pin_pull_low !== e.pin || fail_flag !== e.flag) begin
                n_bad++;
                $display("FAIL %s: pin=%0b flag=%0b expected pin=%0b flag=%0b",
                         e.req, pin_pull_low, fail_flag, e.pin, e.flag);
            end
        end
    end

    task automatic expect_state(input string req, input bit pin, input bit flag);
        exp_t e;
        e.req = req; e.pin = pin; e.flag = flag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic check_val(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        settle(3);
    endtask

    task automatic skip_pulses(input int k);
        wait (skip_req == 0);
        @(negedge clk);
        skip_req = k;
        wait (skip_req == 0);
        settle(6 * NOM);
    endtask

    task automatic count_toggles(input int periods, output int cnt);
        logic prev;
        cnt = 0;
        prev = pin_pull_low;
        repeat (periods * NOM) begin
            @(negedge clk);
            #1;
            if (pin_pull_low !== prev) cnt++;
            prev = pin_pull_low;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        int tg;
        settle(4);
        rst_n = 1'b1;
        settle(2);
        // R1: flag set after reset, soft bit 1 releases pin
        expect_state("R1 reset flag", 1'b0, 1'b1);
        // R9: soft output drives pin
        out_bit = 1'b0; settle(2);
        expect_state("R9 out_bit=0", 1'b1, 1'b1);
        out_bit = 1'b1; settle(2);
        expect_state("R9 out_bit=1", 1'b0, 1'b1);
        // R7: interrupt owns pin, flag 1 -> pull low
        irq_en = 1'b1; settle(2);
        expect_state("R7 irq with flag", 1'b1, 1'b1);
        // R4: clear while oscillator runs
        clear_flag();
        expect_state("R4 clear", 1'b0, 1'b0);
        settle(20 * NOM);
        expect_state("R3 steady osc", 1'b0, 1'b0);
        // R3: three missed pulses stays below threshold
        skip_pulses(2);
        expect_state("R3 two missed", 1'b0, 1'b0);
        skip_pulses(3);
        expect_state("R3 three missed", 1'b0, 1'b0);
        // R2: four missed pulses set the flag
        skip_pulses(4);
        expect_state("R2 four missed", 1'b1, 1'b1);
        // R11: pin registered, one edge latency
        irq_en = 1'b0;
        out_bit = 1'b1;
        #1;
        check_val("R11 pin before edge", pin_pull_low, 1);
        @(negedge clk);
        #1;
        check_val("R11 pin after edge", pin_pull_low, 0);
        clear_flag();
        // R6: detection works with interrupt disabled
        skip_pulses(5);
        expect_state("R6 flag with irq off", 1'b0, 1'b1);
        // R5: clear loses to an ongoing gap
        osc_run = 1'b0;
        settle(8 * NOM);
        clear_flag();
        expect_state("R5 clear during gap", 1'b0, 1'b1);
        osc_run = 1'b1;
        settle(4 * NOM);
        clear_flag();
        expect_state("R4 clear after restart", 1'b0, 1'b0);
        // R8: test wave, 8 toggles per 256 periods
        ftest_en = 1'b1;
        settle(4);
        count_toggles(256, tg);
        check_val("R8 tone toggles", tg, 8);
        // R7: interrupt beats test wave; flag 0 keeps pin released
        irq_en = 1'b1;
        settle(4);
        count_toggles(128, tg);
        check_val("R7 irq over tone toggles", tg, 0);
        expect_state("R7 irq released", 1'b0, 1'b0);
        // R10: backup ignores interrupt, flag and tone
        osc_run = 1'b0;
        settle(8 * NOM);
        osc_run = 1'b1;
        on_backup = 1'b1;
        out_bit = 1'b1;
        settle(2);
        expect_state("R10 backup out=1 flag=1", 1'b0, 1'b1);
        out_bit = 1'b0; settle(2);
        expect_state("R10 backup out=0", 1'b1, 1'b1);
        irq_en = 1'b0;
        count_toggles(128, tg);
        check_val("R10 no tone on backup", tg, 0);
        settle(4);
        finish_run();
    end

endmodule